// File: doc/BRIEF.md
# Reduced-Path Single-Precision Adder

This block sums two 32-bit single-precision floating-point words through a shortened datapath. The word with the greater magnitude becomes the reference. The other word's significand is shifted right to line up with it, then added to or subtracted from the reference significand. A leading-zero count then brings the raw sum back to normal form. The bits that fall off during alignment or normalisation are dropped, and no rounding is applied. Zero, subnormal, infinite and NaN encodings get no special handling, with one exception: an exact cancellation returns positive zero.

The block serves fixed-function pixel pipelines, such as weighted blends in image resizing, where truncated results are acceptable. A parameter selects one of two forms. In the first, one output register sits behind a valid strobe. In the second, the path is purely combinational.

Top module: `fadd_simple`

## Requirements
- R1: Of the two inputs, the one with the larger value in bits 30:0 is the reference operand. When the two values are equal, `a_i` is the reference.
- R2: Every operand's 24-bit significand is its bits 22:0 with a forced one at bit 23, even when the exponent field is 0. For example, 0x00000000 + 0x00000000 gives 0x00800000.
- R3: The other operand's significand is shifted right by the difference of the exponent fields (bits 30:23), with the shift limited to 24. A difference of 24 or more therefore contributes nothing.
- R4: When the sign bits (bit 31) of the inputs are equal, the significands are added. When they differ, the smaller is subtracted from the reference.
- R5: When the raw sum has a carry into bit 24, it is shifted right by one and the exponent is raised by one.
- R6: When the raw sum's leading one lies below bit 23, the sum is shifted left by (leading-zero count − 8) and the exponent is lowered by the same amount.
- R7: The result sign is the sign of the reference operand.
- R8: A raw sum of exactly zero produces 0x00000000.
- R9: Bits shifted out during alignment or normalisation are discarded, with no rounding. For example, 0x3F800001 + 0x3F800002 gives 0x40000001.
- R10: The result exponent field holds the low 8 bits of the computed exponent, which wraps in both directions.
- R11: With `OUT_REG`=1, `valid_o` follows `valid_i` one clock later. `sum_o` loads only on a cycle with `valid_i` high and otherwise holds. An active-low asynchronous reset clears both outputs to 0.
- R12: With `OUT_REG`=0, `sum_o` and `valid_o` follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands valid this cycle |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| valid_o | output | 1 | Result valid |
| sum_o | output | 32 | Result word |

## Verification
The bench builds two copies with the default widths (8-bit exponent, 23-bit fraction): one with `OUT_REG`=1 and one with `OUT_REG`=0. Both copies see the same operands, so every vector checks the one-cycle registered timing and the same-cycle combinational path side by side. The default widths place the alignment cap at 24 and the normalisation target at bit 23. This lets the vectors hit exponent differences of 23, 24 and 30, carries into bit 24, deep cancellation and exponent wrap past 0 and 255.

// File: rtl/fadd_pkg.sv
package fadd_pkg;
  localparam int FP_EXP_W = 8;
  localparam int FP_MAN_W = 23;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } mag_op_e;
endpackage

// File: rtl/fadd_order.sv
module fadd_order
  import fadd_pkg::*;
#(
  parameter int EXP_W = FP_EXP_W,
  parameter int MAN_W = FP_MAN_W,
  localparam int FP_W = 1 + EXP_W + MAN_W
) (
  input  logic [FP_W-1:0]  a_i,
  input  logic [FP_W-1:0]  b_i,
  output logic             big_sign_o,
  output logic [EXP_W-1:0] big_exp_o,
  output logic [MAN_W-1:0] big_frac_o,
  output logic [EXP_W-1:0] small_exp_o,
  output logic [MAN_W-1:0] small_frac_o,
  output mag_op_e          op_o
);
  logic            swap;
  logic [FP_W-1:0] big_w, small_w;

  // ties keep a_i as reference
  assign swap    = b_i[FP_W-2:0] > a_i[FP_W-2:0];
  assign big_w   = swap ? b_i : a_i;
  assign small_w = swap ? a_i : b_i;

  assign big_sign_o   = big_w[FP_W-1];
  assign big_exp_o    = big_w[FP_W-2 -: EXP_W];
  assign big_frac_o   = big_w[MAN_W-1:0];
  assign small_exp_o  = small_w[FP_W-2 -: EXP_W];
  assign small_frac_o = small_w[MAN_W-1:0];
  assign op_o         = (a_i[FP_W-1] == b_i[FP_W-1]) ? OP_ADD : OP_SUB;
endmodule

// File: rtl/fadd_align.sv
module fadd_align
  import fadd_pkg::*;
#(
  parameter int EXP_W = FP_EXP_W,
  parameter int MAN_W = FP_MAN_W,
  localparam int SUM_W = MAN_W + 9,
  localparam int CAP   = MAN_W + 1,
  localparam int SH_W  = $clog2(CAP + 1)
) (
  input  logic [EXP_W-1:0] big_exp_i,
  input  logic [MAN_W-1:0] big_frac_i,
  input  logic [EXP_W-1:0] small_exp_i,
  input  logic [MAN_W-1:0] small_frac_i,
  input  mag_op_e          op_i,
  output logic [SH_W-1:0]  shift_o,
  output logic [SUM_W-1:0] sum_o
);
  logic [EXP_W-1:0] ediff;
  logic [SUM_W-1:0] man_big, man_small, man_al;

  // reference has the larger exponent, so the difference is non-negative
  assign ediff     = big_exp_i - small_exp_i;
  assign shift_o   = (ediff > EXP_W'(CAP)) ? SH_W'(CAP) : SH_W'(ediff);
  assign man_big   = SUM_W'({1'b1, big_frac_i});
  assign man_small = SUM_W'({1'b1, small_frac_i});
  assign man_al    = man_small >> shift_o;
  assign sum_o     = (op_i == OP_ADD) ? man_big + man_al : man_big - man_al;
endmodule

// File: rtl/fadd_lzc.sv
module fadd_lzc #(
  parameter int W = 32,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     data_i,
  output logic [CNT_W-1:0] cnt_o
);
  // priority encoder; later (higher) set bits override lower ones
  always_comb begin
    cnt_o = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (data_i[i]) cnt_o = CNT_W'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fadd_norm.sv
module fadd_norm
  import fadd_pkg::*;
#(
  parameter int EXP_W = FP_EXP_W,
  parameter int MAN_W = FP_MAN_W,
  localparam int SUM_W = MAN_W + 9,
  localparam int CNT_W = $clog2(SUM_W + 1),
  localparam int TGT   = SUM_W - MAN_W - 1,
  localparam int EXX_W = EXP_W + 2,
  localparam int FP_W  = 1 + EXP_W + MAN_W
) (
  input  logic [SUM_W-1:0]     sum_i,
  input  logic [CNT_W-1:0]     clz_i,
  input  logic [EXP_W-1:0]     exp_i,
  input  logic                 sign_i,
  output logic [SUM_W-MAN_W-1:0] lead_o,
  output logic [FP_W-1:0]      res_o
);
  logic [CNT_W-1:0] rsh, lsh;
  logic [SUM_W-1:0] man_n;
  logic [EXX_W-1:0] exp_x;

  assign rsh = CNT_W'(TGT) - clz_i;
  assign lsh = clz_i - CNT_W'(TGT);

  always_comb begin
    if (sum_i == '0) begin
      man_n = '0;
      exp_x = '0;
      res_o = '0;
    end else begin
      if (clz_i <= CNT_W'(TGT)) begin
        man_n = sum_i >> rsh;
        exp_x = EXX_W'(exp_i) + EXX_W'(rsh);
      end else begin
        man_n = sum_i << lsh;
        exp_x = EXX_W'(exp_i) - EXX_W'(lsh);
      end
      // exponent wraps modulo 2^EXP_W, fraction truncated
      res_o = {sign_i, exp_x[EXP_W-1:0], man_n[MAN_W-1:0]};
    end
  end

  assign lead_o = man_n[SUM_W-1:MAN_W];
endmodule

// File: rtl/fadd_simple.sv
module fadd_simple
  import fadd_pkg::*;
#(
  parameter int EXP_W   = FP_EXP_W,
  parameter int MAN_W   = FP_MAN_W,
  parameter bit OUT_REG = 1'b1,
  localparam int FP_W  = 1 + EXP_W + MAN_W,
  localparam int SUM_W = MAN_W + 9,
  localparam int CAP   = MAN_W + 1,
  localparam int SH_W  = $clog2(CAP + 1),
  localparam int CNT_W = $clog2(SUM_W + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [FP_W-1:0] a_i,
  input  logic [FP_W-1:0] b_i,
  output logic            valid_o,
  output logic [FP_W-1:0] sum_o
);
  logic             big_sign;
  logic [EXP_W-1:0] big_exp, small_exp;
  logic [MAN_W-1:0] big_frac, small_frac;
  mag_op_e          op;
  logic [SH_W-1:0]  shift;
  logic [SUM_W-1:0] raw_sum;
  logic [CNT_W-1:0] clz;
  logic [SUM_W-MAN_W-1:0] lead;
  logic [FP_W-1:0]  res_c;

  fadd_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
    .a_i(a_i), .b_i(b_i),
    .big_sign_o(big_sign), .big_exp_o(big_exp), .big_frac_o(big_frac),
    .small_exp_o(small_exp), .small_frac_o(small_frac), .op_o(op)
  );

  fadd_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
    .big_exp_i(big_exp), .big_frac_i(big_frac),
    .small_exp_i(small_exp), .small_frac_i(small_frac),
    .op_i(op), .shift_o(shift), .sum_o(raw_sum)
  );

  fadd_lzc #(.W(SUM_W)) u_lzc (
    .data_i(raw_sum), .cnt_o(clz)
  );

  fadd_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
    .sum_i(raw_sum), .clz_i(clz), .exp_i(big_exp), .sign_i(big_sign),
    .lead_o(lead), .res_o(res_c)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        sum_o   <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) sum_o <= res_c;
      end
    end

    // R11
    vld_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    // R11
    vld_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);
    // R11
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(sum_o));
    // R11
    load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> (sum_o == $past(res_c)));
  end else begin : g_comb
    assign valid_o = valid_i;
    assign sum_o   = res_c;

    // R12
    comb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o == valid_i);
  end

  // R1
  order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {big_exp, big_frac} >= {small_exp, small_frac});
  // R3
  align_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift <= SH_W'(CAP));
  // R5
  norm_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_sum != '0) |-> (lead == 1));
  // R7
  sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_sum != '0) |-> (res_c[FP_W-1] == big_sign));
  // R8
  zero_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_sum == '0) |-> (res_c == '0));
endmodule

// File: tb/fadd_simple_tb_top.sv
module fadd_simple_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  // {req, a, b, expected}
  localparam logic [103:0] VECS [NVEC] = '{
    {8'd5,  32'h3F800000, 32'h3F800000, 32'h40000000}, // R5 carry
    {8'd1,  32'h3F800000, 32'h40000000, 32'h40400000}, // R1 swap, R3 shift 1
    {8'd4,  32'h40400000, 32'hBF800000, 32'h40000000}, // R4 subtract
    {8'd6,  32'h3F800000, 32'hBFC00000, 32'hBF000000}, // R6 left shift, R7
    {8'd8,  32'h3F800000, 32'hBF800000, 32'h00000000}, // R8
    {8'd8,  32'hBF800000, 32'h3F800000, 32'h00000000}, // R8 tie, +0
    {8'd3,  32'h3F800000, 32'h30800000, 32'h3F800000}, // R3 diff 30 capped
    {8'd3,  32'h3F800000, 32'h33800000, 32'h3F800000}, // R3 diff 24
    {8'd3,  32'h3F800000, 32'h34000000, 32'h3F800001}, // R3 diff 23
    {8'd9,  32'h3F800001, 32'h3F800002, 32'h40000001}, // R9 truncation
    {8'd2,  32'h00000000, 32'h00000000, 32'h00800000}, // R2 forced one
    {8'd10, 32'h7F800000, 32'h7F800000, 32'h00000000}, // R10 wrap up
    {8'd10, 32'h00E00000, 32'h80C00000, 32'h7F800000}, // R10 wrap down
    {8'd7,  32'h3F800000, 32'hC0400000, 32'hC0000000}, // R7 sign
    {8'd4,  32'hBF800000, 32'hBF800000, 32'hC0000000}, // R4 both negative
    {8'd3,  32'h3F800000, 32'hB0800000, 32'h3F800000}  // R3 capped subtract
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vin = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        vo_r, vo_c;
  logic [31:0] so_r, so_c;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fadd_simple #(.OUT_REG(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .a_i(a), .b_i(b),
    .valid_o(vo_r), .sum_o(so_r)
  );

  fadd_simple #(.OUT_REG(1'b0)) dut_comb_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .a_i(a), .b_i(b),
    .valid_o(vo_c), .sum_o(so_c)
  );

  task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    // R11 reset state
    #(CLK_PERIOD + 2);
    chk(11, {31'd0, vo_r}, 32'd0);
    chk(11, so_r, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      a   = VECS[i][95:64];
      b   = VECS[i][63:32];
      vin = 1'b1;
      #1;
      chk(int'(VECS[i][103:96]), so_c, VECS[i][31:0]);  // R12 same cycle
      chk(12, {31'd0, vo_c}, 32'd1);
      @(posedge clk);
      #1;
      chk(int'(VECS[i][103:96]), so_r, VECS[i][31:0]);  // R11 one cycle later
      chk(11, {31'd0, vo_r}, 32'd1);
    end

    // R11 hold while valid low; R12 comb follows new operands
    @(negedge clk);
    vin = 1'b0;
    a   = 32'h40400000;
    b   = 32'h40400000;
    #1;
    chk(12, so_c, 32'h40C00000);
    chk(12, {31'd0, vo_c}, 32'd0);
    @(posedge clk);
    #1;
    chk(11, so_r, 32'h3F800000);
    chk(11, {31'd0, vo_r}, 32'd0);

    // R11 load after idle
    @(negedge clk);
    vin = 1'b1;
    @(posedge clk);
    #1;
    chk(11, so_r, 32'h40C00000);

    // R11 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(11, so_r, 32'd0);
    chk(11, {31'd0, vo_r}, 32'd0);
    @(negedge clk);
    vin   = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule